// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block watches for software that has stopped making progress. A 32-bit down-counter advances on each cycle where the `countTick` strobe is high. The strobe stands in for a slow, free-running watchdog time base. The first time-out sets a pending interrupt and restarts the countdown from a programmable start value. Software services the watchdog by writing to a clear register, which also restarts the count. If the interrupt is still pending at the following time-out, the block stops counting. If escalation is enabled, it also raises a reset request that stays high until the block itself is reset.

Every configuration register sits behind a lock. After reset the block is locked. Writes to any register other than the lock register are dropped until a fixed 32-bit key is written to the lock register. Writing any other value to the lock register closes it again. A simple register bus reaches the block: an address, write data, a write strobe, a read strobe, and read data that is combinational while the read strobe is high.

Top module: `twoStageWatchdog`

## Requirements
- R1: After reset the start value and the current count both read 0xFFFFFFFF. Control, raw status and masked status read 0. The lock register (offset 0xC00) reads 1. `irqOut` and `rstReqOut` are low.
- R2: A write of 0x1ACCE551 to offset 0xC00 unlocks the block, and the lock register then reads 0. A write of any other value there locks it, and it reads 1. While locked, writes to offsets 0x00, 0x08 and 0x0C have no effect.
- R3: While interrupt enable is 1 and the counter is not stopped, each cycle with `countTick` high and a nonzero count lowers the count (offset 0x04, read-only) by exactly 1. The count holds on cycles without `countTick`.
- R4: A `countTick` that arrives while the count is 0 and the raw status (offset 0x10, bit 0) is 0 sets the raw status to 1. On the same edge it reloads the count from the start value (offset 0x00).
- R5: A `countTick` that arrives while the count is 0 and the raw status is already 1 stops the counter at 0. If reset enable (control bit 1) is 1, this also raises `rstReqOut`. If reset enable is 0, `rstReqOut` stays low.
- R6: Once high, `rstReqOut` stays high until `rstN` is asserted, even if the interrupt is cleared or the block is reconfigured.
- R7: Any unlocked write to offset 0x0C clears the raw status, reloads the count from the start value and releases a stopped counter. It takes priority over a time-out on the same edge.
- R8: Writing control bit 0 (interrupt enable) to 0 halts the count at its present value. Writing it from 0 to 1 reloads the count from the start value.
- R9: The masked status (offset 0x14, bit 0) and `irqOut` both equal raw status AND interrupt enable.
- R10: A write to the start value does not change the running count. The new value is used from the next reload onward.
- R11: Control bits 31:2 and the upper bits of all status registers read 0. A read of offset 0x0C or of an unmapped offset returns 0. `busRdata` is 0 while `busRe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| countTick | input | 1 | Count advance strobe from the watchdog time base |
| busAddr | input | 12 | Register byte offset |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe, acted on at the clock edge |
| busRe | input | 1 | Read strobe |
| busRdata | output | 32 | Read data, valid while busRe is high |
| irqOut | output | 1 | Interrupt request (masked status) |
| rstReqOut | output | 1 | Sticky reset request |

## Verification
The bench targets the escalation path. It drives a pending interrupt that is disabled and then re-enabled, so the raw status survives into the next period. A design that cleared the status on re-enable would never escalate. A design that ignored the stop would keep counting down from 0.

It also checks:
- **Lock gating, in both directions.** A design that let the clear register bypass the lock would drop a pending interrupt while locked.
- **Start-value writes in the middle of a period.** An eager design would change the running count at once.
- **Second time-out with escalation disabled.** This must stop the counter without raising reset.
- **The sticky reset request after a clear.** A design that tied it to the pending status would drop it.

// File: rtl/wdogPkg.sv
package wdogPkg;
  localparam logic [11:0] OFF_START  = 12'h000;
  localparam logic [11:0] OFF_COUNT  = 12'h004;
  localparam logic [11:0] OFF_CTRL   = 12'h008;
  localparam logic [11:0] OFF_CLEAR  = 12'h00C;
  localparam logic [11:0] OFF_RAW    = 12'h010;
  localparam logic [11:0] OFF_MASKED = 12'h014;
  localparam logic [11:0] OFF_LOCK   = 12'hC00;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

  typedef struct packed {
    logic reload;
    logic decrement;
  } dpStrobe_t;
endpackage

// File: rtl/wdogDatapath.sv
module wdogDatapath
  import wdogPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] cntValue,
  output logic             cntIsZero
);
  localparam logic [CNT_W-1:0] CNT_RESET = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cntReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntReg <= CNT_RESET;
    end else if (strobe.reload) begin
      cntReg <= loadValue;
    end else if (strobe.decrement) begin
      cntReg <= cntReg - CNT_ONE;
    end
  end

  assign cntValue  = cntReg;
  assign cntIsZero = (cntReg == '0);

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decrement && !strobe.reload) |=> (cntValue == $past(cntValue) - CNT_ONE)); // R3

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (cntValue == $past(loadValue))); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.reload && !strobe.decrement) |=> $stable(cntValue)); // R8
endmodule

// File: rtl/wdogControl.sv
module wdogControl
  import wdogPkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              countTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  cntValue,
  input  logic              cntIsZero,
  output dpStrobe_t         strobe,
  output logic [CNT_W-1:0]  loadValue,
  output logic              irqOut,
  output logic              rstReqOut
);
  localparam logic [CNT_W-1:0] START_RESET = {CNT_W{1'b1}};

  logic             locked;
  logic [CNT_W-1:0] startReg;
  logic             intEn;
  logic             resEn;
  logic             rawPending;
  logic             stopped;
  logic             rstReqReg;

  logic hitStart, hitCount, hitCtrl, hitClear, hitRaw, hitMasked, hitLock;
  logic wrOpen, clrWrite, enableRise, running, timeout, firstTimeout, secondTimeout;

  assign hitStart  = (busAddr == ADDR_W'(OFF_START));
  assign hitCount  = (busAddr == ADDR_W'(OFF_COUNT));
  assign hitCtrl   = (busAddr == ADDR_W'(OFF_CTRL));
  assign hitClear  = (busAddr == ADDR_W'(OFF_CLEAR));
  assign hitRaw    = (busAddr == ADDR_W'(OFF_RAW));
  assign hitMasked = (busAddr == ADDR_W'(OFF_MASKED));
  assign hitLock   = (busAddr == ADDR_W'(OFF_LOCK));

  assign wrOpen        = busWe && !locked;
  assign clrWrite      = wrOpen && hitClear;
  assign enableRise    = wrOpen && hitCtrl && busWdata[0] && !intEn;
  assign running       = intEn && !stopped;
  assign timeout       = running && countTick && cntIsZero;
  assign firstTimeout  = timeout && !rawPending && !clrWrite;
  assign secondTimeout = timeout && rawPending && !clrWrite;

  always_comb begin
    strobe.reload    = clrWrite || enableRise || firstTimeout;
    strobe.decrement = running && countTick && !cntIsZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked <= 1'b1;
    end else if (busWe && hitLock) begin
      locked <= (DATA_W'(busWdata) != DATA_W'(UNLOCK_KEY));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startReg <= START_RESET;
      intEn    <= 1'b0;
      resEn    <= 1'b0;
    end else begin
      if (wrOpen && hitStart) startReg <= busWdata[CNT_W-1:0];
      if (wrOpen && hitCtrl) begin
        intEn <= busWdata[0];
        resEn <= busWdata[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawPending <= 1'b0;
      stopped    <= 1'b0;
      rstReqReg  <= 1'b0;
    end else begin
      if (clrWrite) rawPending <= 1'b0;
      else if (firstTimeout) rawPending <= 1'b1;

      if (clrWrite || enableRise) stopped <= 1'b0;
      else if (secondTimeout) stopped <= 1'b1;

      if (secondTimeout && resEn) rstReqReg <= 1'b1;
    end
  end

  assign loadValue = startReg;
  assign irqOut    = rawPending && intEn;
  assign rstReqOut = rstReqReg;

  always_comb begin
    busRdata = '0;
    if (busRe) begin
      if (hitStart)       busRdata = DATA_W'(startReg);
      else if (hitCount)  busRdata = DATA_W'(cntValue);
      else if (hitCtrl)   busRdata = DATA_W'({resEn, intEn});
      else if (hitRaw)    busRdata = DATA_W'(rawPending);
      else if (hitMasked) busRdata = DATA_W'(rawPending && intEn);
      else if (hitLock)   busRdata = DATA_W'(locked);
    end
  end

  AST_LOCKED_START_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (locked && busWe && hitStart) |=> $stable(startReg)); // R2

  AST_LOCKED_PENDING_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (locked && busWe && hitClear && rawPending) |=> rawPending); // R2

  AST_FIRST_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    firstTimeout |=> rawPending); // R4

  AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReqOut) |-> cntIsZero); // R5

  AST_RSTREQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    rstReqOut |=> rstReqOut); // R6

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    clrWrite |=> !rawPending); // R7
endmodule

// File: rtl/twoStageWatchdog.sv
module twoStageWatchdog
  import wdogPkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              countTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              rstReqOut
);
  dpStrobe_t        strobe;
  logic [CNT_W-1:0] loadValue;
  logic [CNT_W-1:0] cntValue;
  logic             cntIsZero;

  wdogControl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrlInst (
    .clk(clk), .rstN(rstN), .countTick(countTick),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .busRe(busRe),
    .busRdata(busRdata), .cntValue(cntValue), .cntIsZero(cntIsZero),
    .strobe(strobe), .loadValue(loadValue), .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

  wdogDatapath #(.CNT_W(CNT_W)) dpInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadValue(loadValue),
    .cntValue(cntValue), .cntIsZero(cntIsZero)
  );
endmodule

// File: tb/twoStageWatchdog_test.sv
module twoStageWatchdog_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        countTick = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic        irqOut, rstReqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  twoStageWatchdog uut (
    .clk(clk), .rstN(rstN), .countTick(countTick), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busRe(busRe), .busRdata(busRdata),
    .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_TK = 2'd2;
  localparam int NVEC = 46;
  // {op, addr, data (write value or tick count), expected read}, req tag in comment
  localparam logic [77:0] VEC [NVEC] = '{
    {OP_RD, 12'hC00, 32'h0, 32'h1},          // R1 locked
    {OP_RD, 12'h000, 32'h0, 32'hFFFFFFFF},   // R1
    {OP_RD, 12'h004, 32'h0, 32'hFFFFFFFF},   // R1
    {OP_RD, 12'h008, 32'h0, 32'h0},          // R1
    {OP_RD, 12'h010, 32'h0, 32'h0},          // R1
    {OP_WR, 12'h000, 32'h5, 32'h0},
    {OP_RD, 12'h000, 32'h0, 32'hFFFFFFFF},   // R2 ignored
    {OP_WR, 12'hC00, 32'h1ACCE551, 32'h0},
    {OP_RD, 12'hC00, 32'h0, 32'h0},          // R2 unlocked
    {OP_WR, 12'h000, 32'h5, 32'h0},
    {OP_RD, 12'h004, 32'h0, 32'hFFFFFFFF},   // R10
    {OP_WR, 12'h008, 32'h1, 32'h0},
    {OP_RD, 12'h004, 32'h0, 32'h5},          // R8 reload on enable
    {OP_TK, 12'h000, 32'd3, 32'h0},
    {OP_RD, 12'h004, 32'h0, 32'h2},          // R3
    {OP_TK, 12'h000, 32'd3, 32'h0},
    {OP_RD, 12'h010, 32'h0, 32'h1},          // R4
    {OP_RD, 12'h004, 32'h0, 32'h5},          // R4
    {OP_RD, 12'h014, 32'h0, 32'h1},          // R9
    {OP_WR, 12'h00C, 32'hABCD, 32'h0},
    {OP_RD, 12'h010, 32'h0, 32'h0},          // R7
    {OP_TK, 12'h000, 32'd2, 32'h0},
    {OP_RD, 12'h004, 32'h0, 32'h3},          // R3
    {OP_WR, 12'h008, 32'h0, 32'h0},
    {OP_TK, 12'h000, 32'd2, 32'h0},
    {OP_RD, 12'h004, 32'h0, 32'h3},          // R8 halted
    {OP_WR, 12'h008, 32'h3, 32'h0},
    {OP_RD, 12'h008, 32'h0, 32'h3},          // R8
    {OP_TK, 12'h000, 32'd6, 32'h0},
    {OP_RD, 12'h010, 32'h0, 32'h1},          // R4
    {OP_WR, 12'h008, 32'h2, 32'h0},
    {OP_RD, 12'h014, 32'h0, 32'h0},          // R9 masked off
    {OP_RD, 12'h010, 32'h0, 32'h1},          // R9 raw kept
    {OP_WR, 12'h008, 32'h3, 32'h0},
    {OP_TK, 12'h000, 32'd6, 32'h0},
    {OP_RD, 12'h004, 32'h0, 32'h0},          // R5 stopped
    {OP_TK, 12'h000, 32'd3, 32'h0},
    {OP_RD, 12'h004, 32'h0, 32'h0},          // R5 stays
    {OP_WR, 12'hC00, 32'hDEAD, 32'h0},
    {OP_RD, 12'hC00, 32'h0, 32'h1},          // R2 relocked
    {OP_WR, 12'h00C, 32'h1, 32'h0},
    {OP_RD, 12'h010, 32'h0, 32'h1},          // R2 clear ignored
    {OP_WR, 12'h008, 32'h0, 32'h0},
    {OP_RD, 12'h008, 32'h0, 32'h3},          // R2 ctrl ignored
    {OP_RD, 12'h00C, 32'h0, 32'h0},          // R11
    {OP_RD, 12'h100, 32'h0, 32'h0}           // R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    #1 d = busRdata;
    busRe = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    countTick = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    countTick = 1'b0;
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: bench timed out");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);
    check("R1 rstReqOut", {31'b0, rstReqOut}, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      case (VEC[v][77:76])
        OP_WR: busWrite(VEC[v][75:64], VEC[v][63:32]);
        OP_TK: ticks(int'(VEC[v][63:32]));
        default: begin
          busRead(VEC[v][75:64], rd);
          check($sformatf("vector %0d", v), rd, VEC[v][31:0]);
        end
      endcase
    end

    // R5 reset request raised by the escalation in the table; R6 sticky
    check("R5 rstReqOut after second timeout", {31'b0, rstReqOut}, 32'h1);
    busWrite(12'hC00, 32'h1ACCE551);
    busWrite(12'h00C, 32'h0);
    check("R6 rstReqOut after clear", {31'b0, rstReqOut}, 32'h1);
    check("R7 irqOut after clear", {31'b0, irqOut}, 32'h0);
    ticks(1);
    busRead(12'h004, rd);
    check("R7 released counter", rd, 32'h4);
    busWrite(12'h008, 32'hFFFFFFFF);
    busRead(12'h008, rd);
    check("R11 reserved ctrl bits", rd, 32'h3);
    busRead(12'h004, rd);
    check("R8 no reload without rise", rd, 32'h4);
    @(negedge clk); busAddr = 12'h004; #1;
    check("R11 idle read data", busRdata, 32'h0);

    // R1 reset clears everything
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R1 rstReqOut after reset", {31'b0, rstReqOut}, 32'h0);
    busRead(12'hC00, rd);
    check("R1 lock after reset", rd, 32'h1);
    busRead(12'h004, rd);
    check("R1 count after reset", rd, 32'hFFFFFFFF);

    // R5 with reset enable 0, R10 start value change mid-run
    busWrite(12'hC00, 32'h1ACCE551);
    busWrite(12'h000, 32'h1);
    busWrite(12'h008, 32'h1);
    ticks(4);
    busRead(12'h004, rd);
    check("R5 stop without reset enable", rd, 32'h0);
    check("R5 no rstReqOut", {31'b0, rstReqOut}, 32'h0);
    check("R9 irqOut pending", {31'b0, irqOut}, 32'h1);
    busWrite(12'h000, 32'h7);
    busRead(12'h004, rd);
    check("R10 start write keeps count", rd, 32'h0);
    busWrite(12'h00C, 32'h0);
    busRead(12'h004, rd);
    check("R10 new start value on reload", rd, 32'h7);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule